// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a compact in-order processor core. Instructions move through five stages: fetch, decode with register read, execute, memory and writeback. Each stage hands its results to the next through an edge-triggered register. The core executes five operations on a word-addressed machine: add, nand, load, store and branch-if-equal. It has eight general registers, and register 0 is an ordinary writable register.

Both memories sit outside the core and have a single-cycle synchronous read. The instruction memory is read at the fetch address. The data-memory address, write data and strobes are driven combinationally from the execute stage, so load data returns during the memory stage. The core handles its own hazards:

- It forwards results from later stages into execute.
- It stalls for one cycle on a load-use dependency.
- It predicts every branch as not taken.
- It resolves branches in the memory stage and squashes the three younger instructions when a branch is taken.

Top module: `pipe5_core`

## Requirements
- R1: Synchronous active-high `rst` clears the program counter, every stage-valid flag and all eight registers. While `rst` is high, `imem_addr` is 0 and `dmem_we` is 0. A register never written since reset reads as 0.
- R2: Instruction encoding is as follows. Bits 31:25 must be zero, otherwise the word is a no-op. Bits 24:22 are the opcode: 0 add, 1 nand, 2 load, 3 store, 4 branch-if-equal, 5-7 no-op. Bits 21:19 are source A and bits 18:16 are source B. Bits 15:0 are a signed offset. Bits 2:0 are the add/nand destination.
- R3: With no stall and no taken branch, the fetch address advances by one every cycle. The instruction memory returns the word one cycle after its address.
- R4: Add writes A+B and nand writes ~(A&B) to the register named by bits 2:0. Load writes the loaded word to the register named by bits 18:16.
- R5: A result is forwarded into execute from the instruction one ahead (memory stage) and from the instruction two ahead (writeback stage). The youngest producer wins.
- R6: A register written in the same cycle it is read in decode supplies the new value, so a consumer three instructions behind its producer sees the result.
- R7: If an instruction in decode reads the destination of a load in execute, fetch and decode hold for exactly one cycle and a bubble enters execute. The consumer then receives the loaded word.
- R8: Load and store use the address A + sign-extended offset. A store writes register B. The offset may be negative.
- R9: A taken branch (A == B) loads the program counter with branch-PC + 1 + offset when it reaches the memory stage. The three younger instructions are squashed, and a squashed store never writes memory.
- R10: A branch with A != B has no effect, and the following instructions execute in order.
- R11: Register 0 can be loaded and read back like any other register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_en | output | 1 | Instruction memory read enable |
| imem_addr | output | ADDR_W | Instruction word address |
| imem_rdata | input | 32 | Instruction word, one cycle after address |
| dmem_en | output | 1 | Data memory access enable |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_addr | output | ADDR_W | Data word address |
| dmem_wdata | output | XLEN | Store data |
| dmem_rdata | input | XLEN | Load data, one cycle after address |

## Verification
The bench builds the core with XLEN=32, ADDR_W=16 and the register-file write-through variant. It attaches 64-word memories, which keep every program, its data and every result location in a window that is reloaded before each run. The bench sweeps the distance between a producer and its consumer from zero to three instructions, which exercises the memory-stage, writeback-stage and register-file paths in turn. It runs a load chain that covers load-use on both operands and a negative offset, and it runs the same branch taken and not taken. Each expected word is computed arithmetically in the bench and compared against memory after the program drains.

// File: rtl/core_pkg.sv
package core_pkg;
   localparam int RF_AW   = 3;
   localparam int NREGS   = 1 << RF_AW;
   localparam int INSTR_W = 32;
   localparam int IMM_W   = 16;

   localparam logic [2:0] OP_ADD   = 3'd0;
   localparam logic [2:0] OP_NAND  = 3'd1;
   localparam logic [2:0] OP_LOAD  = 3'd2;
   localparam logic [2:0] OP_STORE = 3'd3;
   localparam logic [2:0] OP_BEQ   = 3'd4;
   localparam logic [2:0] OP_NOP   = 3'd7;

   typedef enum logic [1:0] {
      SRC_RF  = 2'd0,
      SRC_MEM = 2'd1,
      SRC_WB  = 2'd2,
      SRC_RET = 2'd3
   } fwd_src_e;

   function automatic logic op_writes(input logic [2:0] op);
      return (op == OP_ADD) || (op == OP_NAND) || (op == OP_LOAD);
   endfunction

   function automatic logic op_reads_a(input logic [2:0] op);
      return op <= OP_BEQ;
   endfunction

   function automatic logic op_reads_b(input logic [2:0] op);
      return (op == OP_ADD) || (op == OP_NAND) || (op == OP_STORE) || (op == OP_BEQ);
   endfunction
endpackage

// File: rtl/core_regfile.sv
module core_regfile
   import core_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter bit BYPASS = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [RF_AW-1:0] ra_a,
   input  logic [RF_AW-1:0] ra_b,
   output logic [XLEN-1:0]  rd_a,
   output logic [XLEN-1:0]  rd_b,
   input  logic             we,
   input  logic [RF_AW-1:0] waddr,
   input  logic [XLEN-1:0]  wdata
);
   logic [XLEN-1:0] regs [NREGS];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NREGS; i++) regs[i] <= '0;
      end else if (we) begin
         regs[waddr] <= wdata;
      end
   end

   generate
      if (BYPASS) begin : g_write_through
         assign rd_a = (we && waddr == ra_a) ? wdata : regs[ra_a];
         assign rd_b = (we && waddr == ra_b) ? wdata : regs[ra_b];
      end else begin : g_plain_read
         assign rd_a = regs[ra_a];
         assign rd_b = regs[ra_b];
      end
   endgenerate

   AST_RF_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
      we |=> (regs[$past(waddr)] == $past(wdata)));  // R4
endmodule

// File: rtl/core_alu.sv
module core_alu #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b_reg,
   input  logic [XLEN-1:0] b_imm,
   input  logic            use_imm,
   input  logic            do_nand,
   output logic [XLEN-1:0] y,
   output logic            eq
);
   logic [XLEN-1:0] b_sel;

   always_comb begin
      b_sel = use_imm ? b_imm : b_reg;
      y     = do_nand ? ~(a & b_sel) : (a + b_sel);
      eq    = (a == b_reg);
   end
endmodule

// File: rtl/core_hazard.sv
module core_hazard
   import core_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             id_valid,
   input  logic [2:0]       id_op,
   input  logic [RF_AW-1:0] id_ra,
   input  logic [RF_AW-1:0] id_rb,
   input  logic             ex_valid,
   input  logic [2:0]       ex_op,
   input  logic [RF_AW-1:0] ex_ra,
   input  logic [RF_AW-1:0] ex_rb,
   input  logic [RF_AW-1:0] ex_dst,
   input  logic             mem_wr,
   input  logic [RF_AW-1:0] mem_dst,
   input  logic             wb_we,
   input  logic [RF_AW-1:0] wb_dst,
   input  logic             ret_we,
   input  logic [RF_AW-1:0] ret_dst,
   output logic             stall,
   output fwd_src_e         fwd_a,
   output fwd_src_e         fwd_b
);
   function automatic fwd_src_e pick(input logic [RF_AW-1:0] src);
      if (mem_wr && mem_dst == src)       return SRC_MEM;
      else if (wb_we && wb_dst == src)    return SRC_WB;
      else if (ret_we && ret_dst == src)  return SRC_RET;
      else                                return SRC_RF;
   endfunction

   logic load_in_ex;

   always_comb begin
      load_in_ex = ex_valid && (ex_op == OP_LOAD);
      stall = id_valid && load_in_ex &&
              ((op_reads_a(id_op) && id_ra == ex_dst) ||
               (op_reads_b(id_op) && id_rb == ex_dst));
      fwd_a = pick(ex_ra);
      fwd_b = pick(ex_rb);
   end

   AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
      stall |=> !stall);  // R7
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
   import core_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int ADDR_W    = 16,
   parameter bit RF_BYPASS = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   output logic                imem_en,
   output logic [ADDR_W-1:0]   imem_addr,
   input  logic [INSTR_W-1:0]  imem_rdata,
   output logic                dmem_en,
   output logic                dmem_we,
   output logic [ADDR_W-1:0]   dmem_addr,
   output logic [XLEN-1:0]     dmem_wdata,
   input  logic [XLEN-1:0]     dmem_rdata
);
   localparam int OFF_EXT = XLEN - IMM_W;

   generate
      if (XLEN <= IMM_W) begin : g_bad_xlen
         $error("pipe5_core: XLEN must exceed the offset width");
      end
      if (ADDR_W > XLEN || ADDR_W < 2) begin : g_bad_addr
         $error("pipe5_core: ADDR_W must lie in 2..XLEN");
      end
   endgenerate

   // stage state
   logic [ADDR_W-1:0] pc, id_pc, ex_pc1, mem_target;
   logic              id_valid, ex_valid, mem_valid, wb_we;
   logic [2:0]        id_op, ex_op, mem_op;
   logic [RF_AW-1:0]  id_ra, id_rb, id_rd, ex_ra, ex_rb, ex_rd, ex_dst, mem_dst, wb_dst;
   logic [IMM_W-1:0]  id_off, ex_off;
   logic [XLEN-1:0]   id_va, id_vb, ex_va, ex_vb, opa, opb, imm_x, alu_y;
   logic [XLEN-1:0]   mem_res, mem_val, wb_val;
   logic              alu_eq, mem_taken, stall, flush, mem_wr;
   fwd_src_e          fwd_a, fwd_b;
   logic              ret_we;
   logic [RF_AW-1:0]  ret_dst;
   logic [XLEN-1:0]   ret_val;

   // decode fields
   always_comb begin
      id_op  = (|imem_rdata[INSTR_W-1:25]) ? OP_NOP : imem_rdata[24:22];
      id_ra  = imem_rdata[21:19];
      id_rb  = imem_rdata[18:16];
      id_off = imem_rdata[IMM_W-1:0];
      id_rd  = imem_rdata[2:0];
   end

   core_regfile #(.XLEN(XLEN), .BYPASS(RF_BYPASS)) u_rf (
      .clk(clk), .rst(rst), .ra_a(id_ra), .ra_b(id_rb), .rd_a(id_va), .rd_b(id_vb),
      .we(wb_we), .waddr(wb_dst), .wdata(wb_val));

   core_hazard u_hz (
      .clk(clk), .rst(rst), .id_valid(id_valid), .id_op(id_op), .id_ra(id_ra), .id_rb(id_rb),
      .ex_valid(ex_valid), .ex_op(ex_op), .ex_ra(ex_ra), .ex_rb(ex_rb), .ex_dst(ex_dst),
      .mem_wr(mem_wr), .mem_dst(mem_dst), .wb_we(wb_we), .wb_dst(wb_dst),
      .ret_we(ret_we), .ret_dst(ret_dst), .stall(stall), .fwd_a(fwd_a), .fwd_b(fwd_b));

   // execute operands with forwarding
   always_comb begin
      ex_dst  = (ex_op == OP_LOAD) ? ex_rb : ex_rd;
      imm_x   = {{OFF_EXT{ex_off[IMM_W-1]}}, ex_off};
      mem_val = (mem_op == OP_LOAD) ? dmem_rdata : mem_res;
      mem_wr  = mem_valid && op_writes(mem_op);
      flush   = mem_valid && mem_taken;
      unique case (fwd_a)
         SRC_MEM: opa = mem_val;
         SRC_WB:  opa = wb_val;
         SRC_RET: opa = ret_val;
         default: opa = ex_va;
      endcase
      unique case (fwd_b)
         SRC_MEM: opb = mem_val;
         SRC_WB:  opb = wb_val;
         SRC_RET: opb = ret_val;
         default: opb = ex_vb;
      endcase
   end

   core_alu #(.XLEN(XLEN)) u_alu (
      .a(opa), .b_reg(opb), .b_imm(imm_x),
      .use_imm((ex_op == OP_LOAD) || (ex_op == OP_STORE)),
      .do_nand(ex_op == OP_NAND), .y(alu_y), .eq(alu_eq));

   // memory ports
   always_comb begin
      imem_en    = !rst;
      imem_addr  = stall ? id_pc : pc;
      dmem_en    = ex_valid && !flush && ((ex_op == OP_LOAD) || (ex_op == OP_STORE));
      dmem_we    = ex_valid && !flush && (ex_op == OP_STORE);
      dmem_addr  = alu_y[ADDR_W-1:0];
      dmem_wdata = opb;
   end

   // pipeline registers
   always_ff @(posedge clk) begin
      if (rst) begin
         pc <= '0;  id_pc <= '0;  id_valid <= 1'b0;
         ex_valid <= 1'b0;  ex_op <= OP_NOP;  ex_ra <= '0;  ex_rb <= '0;  ex_rd <= '0;
         ex_off <= '0;  ex_pc1 <= '0;  ex_va <= '0;  ex_vb <= '0;
         mem_valid <= 1'b0;  mem_op <= OP_NOP;  mem_dst <= '0;  mem_res <= '0;
         mem_taken <= 1'b0;  mem_target <= '0;
         wb_we <= 1'b0;  wb_dst <= '0;  wb_val <= '0;
      end else begin
         if (flush) begin
            pc       <= mem_target;
            id_valid <= 1'b0;
         end else if (!stall) begin
            pc       <= pc + 1'b1;
            id_pc    <= pc;
            id_valid <= 1'b1;
         end
         ex_valid <= id_valid && !stall && !flush;
         ex_op    <= id_op;   ex_ra <= id_ra;  ex_rb <= id_rb;  ex_rd <= id_rd;
         ex_off   <= id_off;  ex_pc1 <= id_pc + 1'b1;
         ex_va    <= id_va;   ex_vb <= id_vb;
         mem_valid  <= ex_valid && !flush;
         mem_op     <= ex_op;
         mem_dst    <= ex_dst;
         mem_res    <= alu_y;
         mem_taken  <= (ex_op == OP_BEQ) && alu_eq;
         mem_target <= ex_pc1 + imm_x[ADDR_W-1:0];
         wb_we  <= mem_wr;
         wb_dst <= mem_dst;
         wb_val <= mem_val;
      end
   end

   generate
      if (RF_BYPASS) begin : g_no_retire_fwd
         assign ret_we  = 1'b0;
         assign ret_dst = '0;
         assign ret_val = '0;
      end else begin : g_retire_fwd
         always_ff @(posedge clk) begin
            if (rst) begin
               ret_we <= 1'b0;  ret_dst <= '0;  ret_val <= '0;
            end else begin
               ret_we <= wb_we;  ret_dst <= wb_dst;  ret_val <= wb_val;
            end
         end
      end
   endgenerate

   AST_PC_SEQ: assert property (@(posedge clk) disable iff (rst)
      (!stall && !flush) |=> ((pc - $past(pc)) == ADDR_W'(1)));  // R3
   AST_BUBBLE: assert property (@(posedge clk) disable iff (rst)
      (stall && !flush) |=> (!ex_valid && $stable(pc)));  // R7
   AST_SQUASH: assert property (@(posedge clk) disable iff (rst)
      flush |=> (!id_valid && !ex_valid && !mem_valid));  // R9
   AST_REDIRECT: assert property (@(posedge clk) disable iff (rst)
      flush |=> (pc == $past(mem_target)));  // R9
endmodule

// File: tb/tb_pipe5_core.sv
`timescale 1ns/1ps
module tb_pipe5_core;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        imem_en, dmem_en, dmem_we;
   logic [15:0] imem_addr, dmem_addr;
   logic [31:0] imem_q, dmem_q, dmem_wdata;

   always #10 clk = ~clk;

   pipe5_core dut (
      .clk(clk), .rst(rst), .imem_en(imem_en), .imem_addr(imem_addr), .imem_rdata(imem_q),
      .dmem_en(dmem_en), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
      .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_q));

   logic [31:0] imem [64];
   logic [31:0] dmem [64];
   logic [31:0] prog [64];
   logic [31:0] dinit [64];
   logic        ld_we = 1'b0;
   logic [5:0]  ld_addr = '0;
   logic [31:0] ld_i = '0, ld_d = '0;
   int          np, tests = 0, fails = 0;

   always @(posedge clk) begin
      if (ld_we) begin
         imem[ld_addr] <= ld_i;
         dmem[ld_addr] <= ld_d;
      end else begin
         if (imem_en) imem_q <= imem[imem_addr[5:0]];
         if (dmem_en) begin
            if (dmem_we) dmem[dmem_addr[5:0]] <= dmem_wdata;
            dmem_q <= dmem[dmem_addr[5:0]];
         end
      end
   end

   function automatic logic [31:0] enc(input logic [2:0] op, input logic [2:0] a,
                                       input logic [2:0] b, input logic [15:0] off);
      return {7'b0, op, a, b, off};
   endfunction
   function automatic logic [31:0] i_add(input logic [2:0] d, a, b);  return enc(3'd0, a, b, {13'b0, d}); endfunction
   function automatic logic [31:0] i_nand(input logic [2:0] d, a, b); return enc(3'd1, a, b, {13'b0, d}); endfunction
   function automatic logic [31:0] i_lw(input logic [2:0] d, base, input logic [15:0] off);  return enc(3'd2, base, d, off); endfunction
   function automatic logic [31:0] i_sw(input logic [2:0] s, base, input logic [15:0] off);  return enc(3'd3, base, s, off); endfunction
   function automatic logic [31:0] i_beq(input logic [2:0] a, b, input logic [15:0] off);    return enc(3'd4, a, b, off); endfunction
   localparam logic [31:0] I_NOP = 32'h01C0_0000;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic fresh();
      np = 0;
      for (int i = 0; i < 64; i++) begin
         prog[i]  = I_NOP;
         dinit[i] = 32'hD000_0000 | i;
      end
   endtask

   task automatic emit(input logic [31:0] w);
      prog[np] = w;
      np++;
   endtask

   task automatic run();
      @(negedge clk);
      rst = 1'b1;
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         ld_we = 1'b1; ld_addr = 6'(i); ld_i = prog[i]; ld_d = dinit[i];
      end
      @(negedge clk);
      ld_we = 1'b0;
      @(negedge clk);
      chk("R1 imem_addr in reset", {16'b0, imem_addr}, 32'd0);
      chk("R1 no store in reset", {31'b0, dmem_we}, 32'd0);
      rst = 1'b0;
      repeat (45) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      // dependency distance sweep: R4 R5 R6
      for (int d = 0; d < 4; d++) begin
         logic [31:0] k1, k2;
         k1 = 32'h1357_9BDF + 32'(d);
         k2 = 32'h2468_ACE0 ^ 32'(d);
         fresh();
         dinit[0] = k1; dinit[1] = k2;
         emit(i_lw(3'd1, 3'd0, 16'd0));
         emit(i_lw(3'd2, 3'd0, 16'd1));
         emit(I_NOP); emit(I_NOP); emit(I_NOP);
         emit(i_add(3'd3, 3'd1, 3'd2));
         for (int n = 0; n < d; n++) emit(I_NOP);
         emit(i_add(3'd4, 3'd3, 3'd3));
         emit(i_sw(3'd4, 3'd0, 16'd10));
         emit(i_nand(3'd5, 3'd1, 3'd2));
         emit(i_sw(3'd5, 3'd0, 16'd11));
         emit(i_sw(3'd3, 3'd0, 16'd12));
         run();
         if (d < 2) chk($sformatf("R5 distance %0d", d), dmem[10], 32'(2 * (k1 + k2)));
         else if (d == 2) chk("R6 same-cycle write/read", dmem[10], 32'(2 * (k1 + k2)));
         else chk("R4 add via register file", dmem[10], 32'(2 * (k1 + k2)));
         chk("R4 nand result", dmem[11], ~(k1 & k2));
         chk("R4 add result", dmem[12], k1 + k2);
      end

      // load-use chain: R7 R8 R11 R1
      fresh();
      dinit[0] = 32'h0000_7FF1; dinit[2] = 32'd6; dinit[5] = 32'hCAFE_0005; dinit[3] = 32'h0BAD_F00D;
      emit(i_lw(3'd1, 3'd0, 16'd0));
      emit(i_add(3'd2, 3'd1, 3'd1));
      emit(i_sw(3'd2, 3'd0, 16'd20));
      emit(i_lw(3'd4, 3'd0, 16'd2));
      emit(i_lw(3'd5, 3'd4, 16'hFFFF));
      emit(i_sw(3'd5, 3'd0, 16'd21));
      emit(i_lw(3'd0, 3'd7, 16'd3));
      emit(i_sw(3'd0, 3'd7, 16'd22));
      emit(i_sw(3'd6, 3'd7, 16'd23));
      run();
      chk("R7 load then use", dmem[20], 32'h0000_FFE2);
      chk("R8 negative offset via loaded base", dmem[21], 32'hCAFE_0005);
      chk("R11 register 0 writable", dmem[22], 32'h0BAD_F00D);
      chk("R1 unwritten register is zero", dmem[23], 32'd0);

      // branch taken and not taken: R9 R10
      for (int t = 0; t < 2; t++) begin
         fresh();
         dinit[0] = 32'h5A5A_0001; dinit[1] = 32'h5A5A_0002;
         emit(i_lw(3'd1, 3'd0, 16'd0));
         emit(i_lw(3'd2, 3'd0, (t == 1) ? 16'd0 : 16'd1));
         emit(I_NOP); emit(I_NOP); emit(I_NOP);
         emit(i_beq(3'd1, 3'd2, 16'd3));
         emit(i_sw(3'd1, 3'd0, 16'd30));
         emit(i_sw(3'd1, 3'd0, 16'd31));
         emit(i_sw(3'd1, 3'd0, 16'd32));
         emit(i_sw(3'd1, 3'd0, 16'd33));
         run();
         for (int j = 30; j < 33; j++) begin
            if (t == 1) chk($sformatf("R9 squashed store %0d", j), dmem[j], 32'hD000_0000 | 32'(j));
            else        chk($sformatf("R10 fall-through store %0d", j), dmem[j], 32'h5A5A_0001);
         end
         chk((t == 1) ? "R9 branch target" : "R10 last store", dmem[33], 32'h5A5A_0001);
      end

      // fetch order: R2 R3 (no-op with nonzero upper bits must not write)
      fresh();
      dinit[0] = 32'h0000_0011;
      emit(i_lw(3'd1, 3'd0, 16'd0));
      emit(I_NOP); emit(I_NOP); emit(I_NOP);
      emit(i_add(3'd2, 3'd1, 3'd1) | 32'h0200_0000);
      emit(i_add(3'd3, 3'd1, 3'd1));
      emit(i_sw(3'd2, 3'd0, 16'd40));
      emit(i_sw(3'd3, 3'd0, 16'd41));
      run();
      chk("R2 upper bits make a no-op", dmem[40], 32'd0);
      chk("R3 sequential fetch", dmem[41], 32'h0000_0022);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule